// File: doc/BRIEF.md
# SDIO Card Interrupt Window Detector

This block watches the second data line of an SD-style card bus for a card interrupt, which the card signals by pulling that line low. Because the same line carries payload in 4-bit bus mode, a low level is only taken as an interrupt inside a legal window. In 4-bit mode there are two windows: one while no data phase is running, and one during the gap between two data blocks. In 1-bit mode the line carries no payload, so a low level is accepted at any time. The transfer engine supplies the bus width, the data-phase status and the block-gap indication.

The line is brought into the clock domain through a synchronizer and must read low on consecutive samples before it counts. A qualified low in an enabled window sets a sticky flag for that kind of interrupt: one flag for the idle window, one for the block gap. Firmware clears a flag by pulsing its clear input, which stands for writing 1 to a clear bit. A per-kind enable gates both the detection and the interrupt request. Firmware can therefore turn detection off when the card is a plain memory card.

Top module: `sdio_irq_window_det`

## Requirements
- R1: After reset both flags and the interrupt request are 0.
- R2: When `wide_mode_i` is 0 (1-bit bus), a qualified low sets the idle flag (`flag_idle_o`) even while `data_busy_i` is 1.
- R3: When `wide_mode_i` is 1 and `data_busy_i` is 0, a qualified low sets the idle flag and leaves the gap flag at 0.
- R4: When `wide_mode_i` is 1, `data_busy_i` is 1 and `blk_gap_i` is 1, a qualified low sets the gap flag (`flag_gap_o`) and leaves the idle flag at 0.
- R5: When `wide_mode_i` is 1, `data_busy_i` is 1 and `blk_gap_i` is 0, a low on `dat1_i` has no effect on either flag.
- R6: A low that lasts only one clock sets no flag. A held low sets the flag on the fourth rising edge after `dat1_i` falls: two edges of synchronization and two consecutive low samples.
- R7: A flag is only set while its enable (`en_idle_i` or `en_gap_i`) is 1.
- R8: A flag is set until its clear input is pulsed, and clearing one flag leaves the other unchanged.
- R9: When a set and a clear of the same flag fall in the same cycle, the flag stays 1.
- R10: `irq_o` is 1 exactly when some flag is 1 and its own enable is 1. Dropping the enable masks the request while the flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dat1_i | input | 1 | Raw data line 1 from the pad, asynchronous, low means interrupt |
| wide_mode_i | input | 1 | 1 = 4-bit bus mode, 0 = 1-bit bus mode |
| data_busy_i | input | 1 | A data phase is in progress |
| blk_gap_i | input | 1 | Bus is in the gap between two data blocks |
| en_idle_i | input | 1 | Enable for idle-window interrupts |
| en_gap_i | input | 1 | Enable for block-gap-window interrupts |
| clr_idle_i | input | 1 | One-cycle pulse clearing the idle flag |
| clr_gap_i | input | 1 | One-cycle pulse clearing the gap flag |
| flag_idle_o | output | 1 | Sticky idle-window interrupt flag |
| flag_gap_o | output | 1 | Sticky block-gap interrupt flag |
| irq_o | output | 1 | Interrupt request toward the CPU |

## Verification
The assertions check the flag rules on every cycle. They check that the flags hold, that a clear-only cycle drops a flag, and that a set wins over a clear. They also check that no flag rises unless a qualified low was present the cycle before, that nothing is set during a 4-bit data phase outside the block gap, and that the request is low while both flags are low. Only the bench scenarios can show the rest: the exact four-edge latency, that a one-clock glitch is rejected, that each bus-mode and window combination routes to the right flag, and that masking the request keeps the flag.

// File: rtl/sdio_irq_det_pkg.sv
package sdio_irq_det_pkg;
    localparam int KIND_IDLE = 0;
    localparam int KIND_GAP  = 1;
    localparam int NUM_KINDS = 2;
    typedef logic [NUM_KINDS-1:0] kind_vec_t;
endpackage

// File: rtl/sdio_irq_line_sync.sv
module sdio_irq_line_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dat1_i,
    output logic low_ok_o
);
    localparam int CHAIN = SYNC_STAGES + QUAL_CYCLES - 1;

    typedef struct packed {
        logic [CHAIN-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    // chain[0] is the newest sample; the oldest QUAL_CYCLES bits are synchronized
    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN-2:0], dat1_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{chain: '1};
        else        st_q <= st_d;
    end

    assign low_ok_o = ~|st_q.chain[CHAIN-1 -: QUAL_CYCLES];
endmodule

// File: rtl/sdio_irq_window_sel.sv
module sdio_irq_window_sel
    import sdio_irq_det_pkg::*;
(
    input  logic      low_ok_i,
    input  logic      wide_mode_i,
    input  logic      data_busy_i,
    input  logic      blk_gap_i,
    input  kind_vec_t en_i,
    output kind_vec_t set_o
);
    always_comb begin
        set_o = '0;
        if (low_ok_i) begin
            if (!wide_mode_i || !data_busy_i) begin
                set_o[KIND_IDLE] = en_i[KIND_IDLE];
            end else if (blk_gap_i) begin
                set_o[KIND_GAP] = en_i[KIND_GAP];
            end
        end
    end
endmodule

// File: rtl/sdio_irq_flag_bank.sv
module sdio_irq_flag_bank #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] flag_o
);
    typedef struct packed {
        logic [NUM-1:0] flags;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flags: '0};
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flags;

    for (genvar k = 0; k < NUM; k++) begin : g_chk
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[k] && clr_i[k]) |=> flag_o[k]);
        a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !flag_o[k]);
        a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[k] && !clr_i[k]) |=> flag_o[k]);
    end
endmodule

// File: rtl/sdio_irq_window_det.sv
module sdio_irq_window_det
    import sdio_irq_det_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dat1_i,
    input  logic wide_mode_i,
    input  logic data_busy_i,
    input  logic blk_gap_i,
    input  logic en_idle_i,
    input  logic en_gap_i,
    input  logic clr_idle_i,
    input  logic clr_gap_i,
    output logic flag_idle_o,
    output logic flag_gap_o,
    output logic irq_o
);
    logic      low_ok;
    kind_vec_t en_vec, clr_vec, set_vec, flag_vec;

    always_comb begin
        en_vec             = '0;
        clr_vec            = '0;
        en_vec[KIND_IDLE]  = en_idle_i;
        en_vec[KIND_GAP]   = en_gap_i;
        clr_vec[KIND_IDLE] = clr_idle_i;
        clr_vec[KIND_GAP]  = clr_gap_i;
    end

    sdio_irq_line_sync #(
        .SYNC_STAGES(SYNC_STAGES),
        .QUAL_CYCLES(QUAL_CYCLES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .dat1_i  (dat1_i),
        .low_ok_o(low_ok)
    );

    sdio_irq_window_sel i_win (
        .low_ok_i   (low_ok),
        .wide_mode_i(wide_mode_i),
        .data_busy_i(data_busy_i),
        .blk_gap_i  (blk_gap_i),
        .en_i       (en_vec),
        .set_o      (set_vec)
    );

    sdio_irq_flag_bank #(.NUM(NUM_KINDS)) i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .flag_o(flag_vec)
    );

    assign flag_idle_o = flag_vec[KIND_IDLE];
    assign flag_gap_o  = flag_vec[KIND_GAP];
    assign irq_o       = |(flag_vec & en_vec);

    a_r5_no_set_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode_i && data_busy_i && !blk_gap_i) |-> (set_vec == '0));
    a_r6_rise_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_idle_o) || $rose(flag_gap_o)) |-> $past(low_ok));
    a_r10_quiet_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_idle_o && !flag_gap_o) |-> !irq_o);
    a_r7_one_kind_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));
endmodule

// File: tb/test_sdio_irq_window_det.sv
`timescale 1ns/1ps
module test_sdio_irq_window_det;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dat1 = 1'b1, wide = 1'b0, busy = 1'b0, gap = 1'b0;
    logic en_idle = 1'b0, en_gap = 1'b0, clr_idle = 1'b0, clr_gap = 1'b0;
    logic flag_idle, flag_gap, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic  idle;
        logic  gap;
        logic  irq;
        string req;
    } exp_t;

    exp_t exp_q[$];
    event cmp_ev;

    always #2.5 clk = ~clk;

    sdio_irq_window_det i_sdio_irq_window_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .dat1_i     (dat1),
        .wide_mode_i(wide),
        .data_busy_i(busy),
        .blk_gap_i  (gap),
        .en_idle_i  (en_idle),
        .en_gap_i   (en_gap),
        .clr_idle_i (clr_idle),
        .clr_gap_i  (clr_gap),
        .flag_idle_o(flag_idle),
        .flag_gap_o (flag_gap),
        .irq_o      (irq)
    );

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(cmp_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_tests++;
                if (flag_idle !== e.idle || flag_gap !== e.gap || irq !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s: idle/gap/irq actual %b%b%b expected %b%b%b",
                             e.req, flag_idle, flag_gap, irq, e.idle, e.gap, e.irq);
                end
            end
        end
    end

    task automatic expect_now(input logic i, input logic g, input logic q, input string req);
        exp_t e;
        e.idle = i; e.gap = g; e.irq = q; e.req = req;
        exp_q.push_back(e);
        -> cmp_ev;
        #1;
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic clear_both();
        dat1 = 1'b1;
        cyc(5);
        clr_idle = 1'b1; clr_gap = 1'b1;
        cyc(1);
        clr_idle = 1'b0; clr_gap = 1'b0;
        cyc(1);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(3);
        expect_now(1'b0, 1'b0, 1'b0, "R1 reset state");
        rst_n = 1'b1;
        en_idle = 1'b1; en_gap = 1'b1;
        cyc(2);
        expect_now(1'b0, 1'b0, 1'b0, "R1 after reset release");

        // R6 latency in 4-bit idle window, also R3
        wide = 1'b1; busy = 1'b0;
        @(negedge clk); dat1 = 1'b0;
        cyc(3);
        expect_now(1'b0, 1'b0, 1'b0, "R6 not yet after three edges");
        cyc(1);
        expect_now(1'b1, 1'b0, 1'b1, "R3 idle window sets idle flag on fourth edge");
        clear_both();
        expect_now(1'b0, 1'b0, 1'b0, "R8 both flags cleared");

        // R6 one-clock glitch rejected
        dat1 = 1'b0; cyc(1); dat1 = 1'b1;
        cyc(6);
        expect_now(1'b0, 1'b0, 1'b0, "R6 one-clock low ignored");

        // R5 data phase outside gap
        busy = 1'b1; gap = 1'b0;
        dat1 = 1'b0; cyc(8);
        expect_now(1'b0, 1'b0, 1'b0, "R5 low during data ignored");
        dat1 = 1'b1; cyc(5);
        expect_now(1'b0, 1'b0, 1'b0, "R5 still clear after release");

        // R4 block gap window
        gap = 1'b1;
        dat1 = 1'b0; cyc(6);
        expect_now(1'b0, 1'b1, 1'b1, "R4 gap window sets gap flag");
        dat1 = 1'b1; cyc(5);
        gap = 1'b0;

        // R10 masking
        en_gap = 1'b0; #0.5;
        expect_now(1'b0, 1'b1, 1'b0, "R10 enable off masks irq, flag kept");
        en_gap = 1'b1; #0.5;
        expect_now(1'b0, 1'b1, 1'b1, "R10 enable on restores irq");

        // R8 clear one flag only: set idle too
        busy = 1'b0;
        dat1 = 1'b0; cyc(6);
        expect_now(1'b1, 1'b1, 1'b1, "R8 both flags set");
        dat1 = 1'b1; cyc(5);
        clr_idle = 1'b1; cyc(1); clr_idle = 1'b0;
        expect_now(1'b0, 1'b1, 1'b1, "R8 idle cleared, gap kept");
        clear_both();

        // R2 1-bit mode accepts low during data
        wide = 1'b0; busy = 1'b1; gap = 1'b0;
        dat1 = 1'b0; cyc(6);
        expect_now(1'b1, 1'b0, 1'b1, "R2 1-bit mode accepts low in data phase");

        // R9 set wins while low still held
        clr_idle = 1'b1; cyc(1); clr_idle = 1'b0;
        expect_now(1'b1, 1'b0, 1'b1, "R9 set wins over clear");
        clear_both();
        expect_now(1'b0, 1'b0, 1'b0, "R8 clear after release");

        // R7 enable gates detection
        wide = 1'b1; busy = 1'b0; en_idle = 1'b0;
        dat1 = 1'b0; cyc(6);
        dat1 = 1'b1; cyc(5);
        en_idle = 1'b1; #0.5;
        expect_now(1'b0, 1'b0, 1'b0, "R7 disabled idle window sets nothing");
        busy = 1'b1; gap = 1'b1; en_gap = 1'b0;
        dat1 = 1'b0; cyc(6);
        dat1 = 1'b1; cyc(5);
        en_gap = 1'b1; #0.5;
        expect_now(1'b0, 1'b0, 1'b0, "R7 disabled gap window sets nothing");

        cyc(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule